// File: doc/BRIEF.md
# Two-Port Shared Memory Collision Arbiter

This block puts two identical access ports, left and right, in front of one shared array of 2048 bytes. Each port has an enable, a write strobe, an 11-bit address, write data and registered read data. Most of the time the two ports work independently, and both may write in the same cycle. A collision occurs when both ports are enabled on the same address. The block then lets the port that reached that address first keep its access. It flags the other port through an active-low busy line and drops that port's writes until the collision is over.

Both ports are sampled on one clock. The winner is the port that was already enabled on the colliding address in the previous cycle. The collision can therefore start in two ways: the addresses already match and a second enable arrives, or both ports are enabled and one address moves onto the other. When both ports arrive in the same cycle, the left port wins. The decision stays fixed for as long as the collision lasts.

A parameter selects the mode. As a master, the block makes the busy flags itself and drives them out. As a slave, it drives its busy outputs inactive and takes a busy input for each port from an external master, using it only to block that port's writes.

Top module: `dual_port_arbiter`

## Requirements
- R1: During and after a synchronous reset, both busy outputs are high (inactive) and both read data outputs are 0.
- R2: Writes from both ports in the same cycle to different addresses both take effect. Read data is registered: it shows the word at the enabled port's address one cycle after the request, with the value the array held before any write in that same cycle.
- R3: In master mode, a collision is both ports enabled with equal addresses. One cycle after a collision starts, exactly one busy output is low, never both.
- R4: When the addresses already match, the port whose enable arrives later receives busy (low).
- R5: When both ports are already enabled, the port whose address moves onto the other port's address receives busy.
- R6: When both ports start a collision in the same cycle, the right port receives busy and the left port does not.
- R7: Busy stays on the same port for every cycle the collision continues.
- R8: Busy returns high one cycle after the collision ends, whether an enable drops or an address changes.
- R9: In master mode, a write from the losing port is ignored in every cycle of the collision, including its first cycle. The losing port's reads still return array data. A write in the first cycle after the collision ends takes effect.
- R10: In slave mode, both busy outputs stay high, collisions flag nothing, and a port's write is ignored in any cycle where that port's busy input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | 11 | Left port address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port registered read data |
| l_busy_n | output | 1 | Left busy flag, active low (master mode) |
| l_busy_n_in | input | 1 | Left busy input from external master, active low (slave mode) |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | 11 | Right port address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port registered read data |
| r_busy_n | output | 1 | Right busy flag, active low (master mode) |
| r_busy_n_in | input | 1 | Right busy input from external master, active low (slave mode) |

## Verification
The assertions check the busy pair on every cycle, using only the port inputs. Busy is never low on both sides. Any collision flags exactly one side on the next cycle. A flagged side stays flagged while the collision lasts. Both flags are released one cycle after the collision ends, and in slave mode the flags never leave the inactive level. Only the bench's scenarios can show which side wins for each order of arrival, and whether a blocked write left the array unchanged. For the array contents, the bench writes a value, lets the collision run and reads the address back.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  // Ownership of a colliding address; the non-owner is the flagged side.
  typedef enum logic [1:0] {
    ARB_IDLE       = 2'd0,
    ARB_LEFT_OWNS  = 2'd1,
    ARB_RIGHT_OWNS = 2'd2
  } arb_state_e;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L    = 0;
  localparam int unsigned PORT_R    = 1;

endpackage

// File: rtl/dpa_collision_detect.sv
module dpa_collision_detect #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              contend,
  output logic              l_held,
  output logic              r_held
);

  logic              l_en_q, r_en_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;

  // Previous-cycle view of each port, used to tell who arrived first.
  always_ff @(posedge clk) begin
    if (rst) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
    end
  end

  always_comb begin
    contend = l_en && r_en && (l_addr == r_addr);
    // A port "holds" the address when it was already enabled on it last cycle.
    l_held  = l_en_q && (l_addr_q == l_addr);
    r_held  = r_en_q && (r_addr_q == r_addr);
  end

endmodule

// File: rtl/dpa_busy_ctrl.sv
module dpa_busy_ctrl
  import dpa_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic contend,
  input  logic l_held,
  input  logic r_held,
  input  logic l_we_req,
  input  logic r_we_req,
  input  logic l_busy_n_in,
  input  logic r_busy_n_in,
  output logic l_we_ok,
  output logic r_we_ok,
  output logic l_busy_n,
  output logic r_busy_n
);

  arb_state_e state_q, state_d;
  logic       l_lose, r_lose;

  always_comb begin
    if (!contend) begin
      state_d = ARB_IDLE;
    end else if (state_q != ARB_IDLE) begin
      state_d = state_q;
    end else if (r_held && !l_held) begin
      state_d = ARB_RIGHT_OWNS;
    end else begin
      state_d = ARB_LEFT_OWNS;   // left first, or a same-cycle tie
    end
    l_lose = (state_d == ARB_RIGHT_OWNS);
    r_lose = (state_d == ARB_LEFT_OWNS);
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ARB_IDLE;
    else     state_q <= state_d;
  end

  // Write gating takes the current-cycle decision so the onset cycle is covered.
  always_comb begin
    l_we_ok = l_we_req && (IS_MASTER ? !l_lose : l_busy_n_in);
    r_we_ok = r_we_req && (IS_MASTER ? !r_lose : r_busy_n_in);
  end

  generate
    if (IS_MASTER) begin : g_master
      logic l_busy_q, r_busy_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          l_busy_q <= 1'b1;
          r_busy_q <= 1'b1;
        end else begin
          l_busy_q <= !l_lose;
          r_busy_q <= !r_lose;
        end
      end
      assign l_busy_n = l_busy_q;
      assign r_busy_n = r_busy_q;
    end else begin : g_slave
      assign l_busy_n = 1'b1;
      assign r_busy_n = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/dpa_storage.sv
module dpa_storage
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2048
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_PORTS-1:0]                en,
  input  logic [NUM_PORTS-1:0]                we,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    addr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]    wdata,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]    rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Both write ports in one process; the gating upstream keeps them apart on a collision.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (we[p]) mem[addr[p]] <= wdata[p];
    end
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
      always_ff @(posedge clk) begin
        if (rst)        rdata[p] <= '0;
        else if (en[p]) rdata[p] <= mem[addr[p]];
      end
    end
  endgenerate

endmodule

// File: rtl/dual_port_arbiter.sv
module dual_port_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned DATA_W    = 8,
  parameter bit          IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_busy_n,
  input  logic              l_busy_n_in,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_busy_n,
  input  logic              r_busy_n_in
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic contend, l_held, r_held;
  logic l_we_ok, r_we_ok;

  logic [NUM_PORTS-1:0]             mem_en, mem_we;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] mem_addr;
  logic [NUM_PORTS-1:0][DATA_W-1:0] mem_wdata, mem_rdata;

  dpa_collision_detect #(.ADDR_W(ADDR_W)) u_detect (
    .clk     (clk),
    .rst     (rst),
    .l_en    (l_en),
    .l_addr  (l_addr),
    .r_en    (r_en),
    .r_addr  (r_addr),
    .contend (contend),
    .l_held  (l_held),
    .r_held  (r_held)
  );

  dpa_busy_ctrl #(.IS_MASTER(IS_MASTER)) u_busy (
    .clk         (clk),
    .rst         (rst),
    .contend     (contend),
    .l_held      (l_held),
    .r_held      (r_held),
    .l_we_req    (l_en && l_we),
    .r_we_req    (r_en && r_we),
    .l_busy_n_in (l_busy_n_in),
    .r_busy_n_in (r_busy_n_in),
    .l_we_ok     (l_we_ok),
    .r_we_ok     (r_we_ok),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n)
  );

  always_comb begin
    mem_en[PORT_L]    = l_en;
    mem_en[PORT_R]    = r_en;
    mem_we[PORT_L]    = l_we_ok;
    mem_we[PORT_R]    = r_we_ok;
    mem_addr[PORT_L]  = l_addr;
    mem_addr[PORT_R]  = r_addr;
    mem_wdata[PORT_L] = l_wdata;
    mem_wdata[PORT_R] = r_wdata;
  end

  dpa_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst   (rst),
    .en    (mem_en),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assign l_rdata = mem_rdata[PORT_L];
  assign r_rdata = mem_rdata[PORT_R];

endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
  parameter int unsigned ADDR_W    = 11,
  parameter bit          IS_MASTER = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              l_en,
  input logic              r_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_n,
  input logic              r_busy_n
);

  logic clash;
  assign clash = l_en && r_en && (l_addr == r_addr);

  generate
    if (IS_MASTER) begin : g_m
      AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (rst)
        (l_busy_n || r_busy_n)); // R3
      AST_CLASH_FLAGS_ONE: assert property (@(posedge clk) disable iff (rst)
        clash |=> (l_busy_n != r_busy_n)); // R3
      AST_LEFT_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!l_busy_n && clash) |=> !l_busy_n); // R7
      AST_RIGHT_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!r_busy_n && clash) |=> !r_busy_n); // R7
      AST_RELEASE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !clash |=> (l_busy_n && r_busy_n)); // R8
    end else begin : g_s
      AST_SLAVE_FLAGS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (l_busy_n && r_busy_n)); // R10
    end
  endgenerate

endmodule

bind dual_port_arbiter dpa_checker #(.ADDR_W(ADDR_W), .IS_MASTER(IS_MASTER)) u_dpa_checker (
  .clk      (clk),
  .rst      (rst),
  .l_en     (l_en),
  .r_en     (r_en),
  .l_addr   (l_addr),
  .r_addr   (r_addr),
  .l_busy_n (l_busy_n),
  .r_busy_n (r_busy_n)
);

// File: tb/test_dual_port_arbiter.sv
module test_dual_port_arbiter;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  // master-mode stimulus
  logic m_len = 0, m_lwe = 0, m_ren = 0, m_rwe = 0;
  logic [10:0] m_la = 0, m_ra = 0;
  logic [7:0]  m_ld = 0, m_rd = 0;
  logic [7:0]  m_lq, m_rq;
  logic        m_lb, m_rb;
  // slave-mode stimulus
  logic s_len = 0, s_lwe = 0, s_ren = 0, s_rwe = 0;
  logic [10:0] s_la = 0, s_ra = 0;
  logic [7:0]  s_ld = 0, s_rd = 0;
  logic        s_lbi = 1, s_rbi = 1;
  logic [7:0]  s_lq, s_rq;
  logic        s_lb, s_rb;

  dual_port_arbiter #(.IS_MASTER(1'b1)) i_dual_port_arbiter (
    .clk(clk), .rst(rst),
    .l_en(m_len), .l_we(m_lwe), .l_addr(m_la), .l_wdata(m_ld), .l_rdata(m_lq),
    .l_busy_n(m_lb), .l_busy_n_in(1'b1),
    .r_en(m_ren), .r_we(m_rwe), .r_addr(m_ra), .r_wdata(m_rd), .r_rdata(m_rq),
    .r_busy_n(m_rb), .r_busy_n_in(1'b1)
  );

  dual_port_arbiter #(.IS_MASTER(1'b0)) i_dual_port_arbiter_slave (
    .clk(clk), .rst(rst),
    .l_en(s_len), .l_we(s_lwe), .l_addr(s_la), .l_wdata(s_ld), .l_rdata(s_lq),
    .l_busy_n(s_lb), .l_busy_n_in(s_lbi),
    .r_en(s_ren), .r_we(s_rwe), .r_addr(s_ra), .r_wdata(s_rd), .r_rdata(s_rq),
    .r_busy_n(s_rb), .r_busy_n_in(s_rbi)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  typedef struct {
    int       due;
    bit       slv;
    bit       port;   // 0 left, 1 right
    logic [7:0] exp;
    string    req;
  } rd_item_t;
  rd_item_t sb[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard: read result is due one cycle later
  task automatic expect_rd(bit slv, bit port, logic [7:0] exp, string req);
    rd_item_t it;
    it.due = cyc + 1; it.slv = slv; it.port = port; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // monitor side
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      while (sb.size() > 0 && sb[0].due == cyc) begin
        rd_item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        act = it.slv ? (it.port ? s_rq : s_lq) : (it.port ? m_rq : m_lq);
        chk(it.req, {24'h0, act}, {24'h0, it.exp});
      end
    end
  end

  task automatic mdrv(bit le, bit lw, logic [10:0] la, logic [7:0] ld,
                      bit re, bit rw, logic [10:0] ra, logic [7:0] rd);
    @(negedge clk);
    m_len = le; m_lwe = lw; m_la = la; m_ld = ld;
    m_ren = re; m_rwe = rw; m_ra = ra; m_rd = rd;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic mbusy(bit el, bit er, string req);
    chk({req, " left busy_n"},  {31'h0, m_lb}, {31'h0, el});
    chk({req, " right busy_n"}, {31'h0, m_rb}, {31'h0, er});
  endtask

  task automatic midle();
    mdrv(0, 0, 0, 0, 0, 0, 0, 0); step();
  endtask

  task automatic mwrite_l(logic [10:0] a, logic [7:0] d);
    mdrv(1, 1, a, d, 0, 0, 0, 0); step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    mbusy(1, 1, "R1");
    chk("R1 left rdata",  {24'h0, m_lq}, 32'h0);
    chk("R1 right rdata", {24'h0, m_rq}, 32'h0);
    chk("R1 slave busy_n", {30'h0, s_lb, s_rb}, 32'h3);
    @(negedge clk); rst = 1'b0;
    step();

    // R2: independent same-cycle writes both commit
    mdrv(1, 1, 11'd5, 8'hA5, 1, 1, 11'd6, 8'h5A); step();
    mdrv(1, 0, 11'd5, 0, 1, 0, 11'd6, 0);
    expect_rd(0, 0, 8'hA5, "R2 left readback");
    expect_rd(0, 1, 8'h5A, "R2 right readback");
    step();
    mdrv(1, 0, 11'd6, 0, 1, 0, 11'd5, 0);
    expect_rd(0, 0, 8'h5A, "R2 cross readback left");
    expect_rd(0, 1, 8'hA5, "R2 cross readback right");
    step();

    // preload
    mwrite_l(11'd10, 8'h11);
    mwrite_l(11'd20, 8'h20);
    mwrite_l(11'd30, 8'h30);
    mwrite_l(11'd50, 8'h50);
    midle(); mbusy(1, 1, "R8 idle");

    // R4: left enabled first, right enables onto addr 10 with a write
    mdrv(1, 0, 11'd10, 0, 0, 0, 0, 0); step(); mbusy(1, 1, "R3 no clash");
    mdrv(1, 0, 11'd10, 0, 1, 1, 11'd10, 8'h77);
    expect_rd(0, 0, 8'h11, "R9 winner read");
    expect_rd(0, 1, 8'h11, "R9 loser read");
    step(); mbusy(1, 0, "R4");
    mdrv(1, 0, 11'd10, 0, 1, 1, 11'd10, 8'h77);
    expect_rd(0, 1, 8'h11, "R9 loser write blocked");
    step(); mbusy(1, 0, "R7");
    // left drops: right write now commits; read-first still shows old data
    mdrv(0, 0, 0, 0, 1, 1, 11'd10, 8'h77);
    expect_rd(0, 1, 8'h11, "R9 array unchanged during clash");
    step(); mbusy(1, 1, "R8 enable drop");
    mdrv(0, 0, 0, 0, 1, 0, 11'd10, 0);
    expect_rd(0, 1, 8'h77, "R9 write after release");
    step();
    midle();

    // R5: right moves its address onto left's
    mdrv(1, 0, 11'd20, 0, 1, 0, 11'd21, 0); step(); mbusy(1, 1, "R5 apart");
    mdrv(1, 0, 11'd20, 0, 1, 1, 11'd20, 8'h99); step(); mbusy(1, 0, "R5 right moves");
    midle(); mbusy(1, 1, "R8");
    mdrv(1, 0, 11'd20, 0, 0, 0, 0, 0);
    expect_rd(0, 0, 8'h20, "R9 onset write blocked");
    step();

    // R5: left moves onto right's address with a write
    mdrv(1, 0, 11'd31, 0, 1, 0, 11'd30, 0); step();
    mdrv(1, 1, 11'd30, 8'h44, 1, 0, 11'd30, 0); step(); mbusy(0, 1, "R5 left moves");
    mdrv(1, 1, 11'd30, 8'h44, 1, 0, 11'd33, 0); step(); mbusy(1, 1, "R8 address change");
    mdrv(1, 0, 11'd30, 0, 0, 0, 0, 0);
    expect_rd(0, 0, 8'h44, "R9 commit after address release");
    step();
    midle();

    // R6: same-cycle arrival
    mdrv(1, 0, 11'd40, 0, 1, 0, 11'd40, 0); step(); mbusy(1, 0, "R6 tie");
    mdrv(1, 0, 11'd40, 0, 1, 0, 11'd40, 0); step(); mbusy(1, 0, "R7 tie held");
    midle(); mbusy(1, 1, "R8");

    // R4 mirrored + R7: right first, left enables later, held three cycles
    mdrv(0, 0, 0, 0, 1, 0, 11'd50, 0); step();
    for (int k = 0; k < 3; k++) begin
      mdrv(1, 1, 11'd50, 8'hEE, 1, 0, 11'd50, 0); step();
      mbusy(0, 1, "R7 left held");
    end
    midle();
    mdrv(0, 0, 0, 0, 1, 0, 11'd50, 0);
    expect_rd(0, 1, 8'h50, "R9 left loser writes dropped");
    step();
    midle();

    // R10: slave mode
    @(negedge clk);
    s_len = 1; s_lwe = 1; s_la = 11'd60; s_ld = 8'h60;
    s_ren = 1; s_rwe = 1; s_ra = 11'd61; s_rd = 8'h61;
    step();
    @(negedge clk);
    s_lbi = 0; s_ld = 8'hAB; s_rd = 8'hCD;   // left write blocked, right allowed
    step();
    chk("R10 slave busy outputs", {30'h0, s_lb, s_rb}, 32'h3);
    @(negedge clk);
    s_lwe = 0; s_rwe = 0; s_lbi = 1;
    expect_rd(1, 0, 8'h60, "R10 blocked slave write");
    expect_rd(1, 1, 8'hCD, "R10 unblocked slave write");
    step();
    @(negedge clk);
    s_lwe = 1; s_ld = 8'hAB; s_ra = 11'd60;   // collision in slave mode, left writes
    step();
    chk("R10 no flag on collision", {30'h0, s_lb, s_rb}, 32'h3);
    @(negedge clk);
    s_lwe = 0; s_ren = 0;
    expect_rd(1, 0, 8'hAB, "R10 write with busy input high");
    step();
    @(negedge clk); s_len = 0;
    step(); step();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule